// File: doc/BRIEF.md
# Exception Priority and Entry Controller

This block decides which pending exception a processor core takes next and performs the state bookkeeping of the entry. Five sources compete: a system reset request, a machine check, a fault raised by the instruction being executed, an external interrupt line and the decrementer. They are ranked in a fixed order. Two bits of an internal machine-state register gate them. The external-enable bit masks both the external interrupt and the decrementer. The machine-check-enable bit decides whether a machine check is serviced or freezes the core.

When a source wins, the controller copies the current instruction address into save register 0 and the machine-state word into save register 1. It then drops to supervisor mode, clears the external-enable bit and presents a handler address for one cycle. The handler addresses sit in 256-byte slots of a 16 KB table at a base set by a parameter. A return strobe reloads the state word from save register 1 and presents the saved address as the resume point. A machine check that arrives while it is disabled puts the block in a check-stop state, which only a system reset request can end.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While and after `rst_n` is low, `msr_o`, `srr0_o` and `srr1_o` are zero, `check_stop` is 0, `vec_valid` and `resume_valid` are 0, and no decrementer event is pending.
- R2: When several sources request in the same cycle, only one is taken, in this ranking from highest: system reset, machine check, instruction fault, external interrupt, decrementer. The lower ones stay pending only as their own rules allow.
- R3: The handler address presented with `vec_valid` equals `VEC_BASE + slot*256`, with slot 1 for reset, 2 for machine check, 7 for instruction fault, 5 for external interrupt and 9 for decrementer. `vec_valid` is high for exactly the one cycle after the clock edge on which the request was sampled.
- R4: On any entry other than reset, `srr0_o` takes the `insn_addr` value sampled on the entry edge and `srr1_o` takes the `msr_o` value from before that edge.
- R5: State word bit 0 is the external enable, bit 1 the machine-check enable, and bit 2 the user-mode flag (0 means supervisor). On entry, bits 0 and 2 are cleared and every other bit is kept.
- R6: The level-sensitive `ext_irq` and a pending decrementer event are taken only while bit 0 of `msr_o` is 1. While that bit is 0 they wait, and they are taken on the first edge on which it is 1.
- R7: A one-cycle `dec_event` pulse sets a pending flag. That flag is cleared when the decrementer exception is taken, so one pulse yields exactly one decrementer entry.
- R8: A machine check sampled while bit 1 of `msr_o` is 0 sets `check_stop` on the next edge and presents no vector. While `check_stop` is 1, every input except `sys_reset_req` is ignored and the state word is unchanged.
- R9: A `rfi` pulse with no exception taken on the same edge restores `msr_o` from `srr1_o`. On the cycle after that edge, `resume_valid` is high and `resume_addr` holds the value `srr0_o` had.
- R10: `sys_reset_req` clears `msr_o`, `srr0_o`, `srr1_o`, the decrementer pending flag and `check_stop`, and presents the reset handler address, whatever else is requested.
- R11: A `msr_wr` pulse loads `msr_wdata` into the state word on the next edge unless an exception or a return is taken on that edge; in that case the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_reset_req | input | 1 | System reset exception request |
| mchk_req | input | 1 | Machine check request |
| insn_fault_req | input | 1 | Fault raised by the current instruction |
| ext_irq | input | 1 | Level-sensitive external interrupt |
| dec_event | input | 1 | Decrementer expiry pulse |
| insn_addr | input | AW | Address of the current instruction |
| rfi | input | 1 | Return-from-interrupt strobe |
| msr_wr | input | 1 | State word write strobe |
| msr_wdata | input | MSR_W | State word write value |
| msr_o | output | MSR_W | Machine-state word |
| srr0_o | output | AW | Saved instruction address |
| srr1_o | output | MSR_W | Saved state word |
| vec_valid | output | 1 | Exception entry taken, handler address valid |
| vec_addr | output | AW | Handler address |
| resume_valid | output | 1 | Return taken, resume address valid |
| resume_addr | output | AW | Address to resume at |
| check_stop | output | 1 | Core halted after a disabled machine check |

## Verification
Simultaneous requests of every ranking pair (machine check against all lower sources, instruction fault against external, external against decrementer, reset against machine check) show whether the fixed order is honoured and whether the losers are held or dropped. Sequences of entry followed by return show that the external enable is cleared by entry and restored by return, so a masked level interrupt or a stored decrementer event fires exactly once after the return. A disabled machine check followed by a burst of other requests shows the check-stop freeze, and a reset request ends it. A state write that collides with an entry separates the priority of entry over the write from the plain write path.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_RESET = 3'd1,
    CLS_MCHK  = 3'd2,
    CLS_INSN  = 3'd3,
    CLS_EXT   = 3'd4,
    CLS_DEC   = 3'd5
  } exc_cls_e;

  // State word bit positions
  localparam int unsigned MSR_EE = 0;  // external / decrementer enable
  localparam int unsigned MSR_ME = 1;  // machine check enable
  localparam int unsigned MSR_UM = 2;  // user mode when set

  // Slot index of each class in the handler table
  function automatic logic [7:0] slot_of(exc_cls_e c);
    case (c)
      CLS_RESET: slot_of = 8'd1;
      CLS_MCHK:  slot_of = 8'd2;
      CLS_INSN:  slot_of = 8'd7;
      CLS_EXT:   slot_of = 8'd5;
      CLS_DEC:   slot_of = 8'd9;
      default:   slot_of = 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
  import exc_pkg::*;
(
  input  logic     sys_rst_req,
  input  logic     mchk_req,
  input  logic     insn_req,
  input  logic     ext_req,
  input  logic     dec_pend,
  input  logic     ext_en,
  input  logic     halted,
  input  logic     mchk_en,
  output exc_cls_e cls,
  output logic     stop_go
);

  localparam int NSRC = 5;
  localparam int IW   = $clog2(NSRC);

  logic [NSRC-1:0] live;
  logic [IW-1:0]   win;
  logic            any;

  // index 0 is the highest rank
  assign live = {dec_pend & ext_en, ext_req & ext_en, insn_req, mchk_req, sys_rst_req};

  always_comb begin
    any = 1'b0;
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (live[i]) begin
        any = 1'b1;
        win = IW'(i);
      end
    end
  end

  always_comb begin
    cls     = CLS_NONE;
    stop_go = 1'b0;
    if (any && (sys_rst_req || !halted)) begin
      case (win)
        IW'(0): cls = CLS_RESET;
        IW'(1): begin
          if (mchk_en) cls = CLS_MCHK;
          else         stop_go = 1'b1;
        end
        IW'(2): cls = CLS_INSN;
        IW'(3): cls = CLS_EXT;
        IW'(4): cls = CLS_DEC;
        default: cls = CLS_NONE;
      endcase
    end
  end

endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
  import exc_pkg::*;
#(
  parameter int unsigned    AW         = 32,
  parameter logic [AW-1:0]  VEC_BASE   = '0,
  parameter int unsigned    SLOT_SHIFT = 8
) (
  input  exc_cls_e      cls,
  output logic [AW-1:0] vec
);

  logic [AW-1:0] offset;

  assign offset = AW'(slot_of(cls)) << SLOT_SHIFT;
  assign vec    = VEC_BASE + offset;

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned MSR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  exc_cls_e         cls,
  input  logic             stop_go,
  input  logic [AW-1:0]    insn_addr,
  input  logic             rfi,
  input  logic             msr_wr,
  input  logic [MSR_W-1:0] msr_wdata,
  input  logic             dec_event,
  input  logic [AW-1:0]    vec_in,
  output logic [MSR_W-1:0] msr_q,
  output logic [AW-1:0]    srr0_q,
  output logic [MSR_W-1:0] srr1_q,
  output logic             dec_pend_q,
  output logic             halted_q,
  output logic             vec_valid_q,
  output logic [AW-1:0]    vec_addr_q,
  output logic             resume_valid_q,
  output logic [AW-1:0]    resume_addr_q
);

  localparam logic [MSR_W-1:0] ENTRY_KEEP =
    ~((MSR_W'(1) << MSR_EE) | (MSR_W'(1) << MSR_UM));

  logic [MSR_W-1:0] msr_d;
  logic [AW-1:0]    srr0_d;
  logic [MSR_W-1:0] srr1_d;
  logic             dec_pend_d;
  logic             halted_d;
  logic             vec_valid_d;
  logic             resume_valid_d;
  logic             take;

  assign take = (cls != CLS_NONE);

  // next-state
  always_comb begin
    msr_d          = msr_q;
    srr0_d         = srr0_q;
    srr1_d         = srr1_q;
    dec_pend_d     = dec_pend_q;
    halted_d       = halted_q;
    vec_valid_d    = 1'b0;
    resume_valid_d = 1'b0;
    if (cls == CLS_RESET) begin
      msr_d       = '0;
      srr0_d      = '0;
      srr1_d      = '0;
      dec_pend_d  = 1'b0;
      halted_d    = 1'b0;
      vec_valid_d = 1'b1;
    end else if (!halted_q) begin
      dec_pend_d = dec_pend_q | dec_event;
      if (stop_go) begin
        halted_d = 1'b1;
      end else if (take) begin
        srr0_d      = insn_addr;
        srr1_d      = msr_q;
        msr_d       = msr_q & ENTRY_KEEP;
        vec_valid_d = 1'b1;
        if (cls == CLS_DEC) dec_pend_d = dec_event;
      end else if (rfi) begin
        msr_d          = srr1_q;
        resume_valid_d = 1'b1;
      end else if (msr_wr) begin
        msr_d = msr_wdata;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msr_q          <= '0;
      srr0_q         <= '0;
      srr1_q         <= '0;
      dec_pend_q     <= 1'b0;
      halted_q       <= 1'b0;
      vec_valid_q    <= 1'b0;
      resume_valid_q <= 1'b0;
    end else begin
      msr_q          <= msr_d;
      srr0_q         <= srr0_d;
      srr1_q         <= srr1_d;
      dec_pend_q     <= dec_pend_d;
      halted_q       <= halted_d;
      vec_valid_q    <= vec_valid_d;
      resume_valid_q <= resume_valid_d;
    end
  end

  // address outputs: loaded only under their strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_addr_q <= '0;
    end else if (vec_valid_d) begin
      vec_addr_q <= vec_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resume_addr_q <= '0;
    end else if (resume_valid_d) begin
      resume_addr_q <= srr0_q;
    end
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned   AW         = 32,
  parameter int unsigned   MSR_W      = 8,
  parameter int unsigned   SLOT_SHIFT = 8,
  parameter logic [AW-1:0] VEC_BASE   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_reset_req,
  input  logic             mchk_req,
  input  logic             insn_fault_req,
  input  logic             ext_irq,
  input  logic             dec_event,
  input  logic [AW-1:0]    insn_addr,
  input  logic             rfi,
  input  logic             msr_wr,
  input  logic [MSR_W-1:0] msr_wdata,
  output logic [MSR_W-1:0] msr_o,
  output logic [AW-1:0]    srr0_o,
  output logic [MSR_W-1:0] srr1_o,
  output logic             vec_valid,
  output logic [AW-1:0]    vec_addr,
  output logic             resume_valid,
  output logic [AW-1:0]    resume_addr,
  output logic             check_stop
);

  exc_cls_e      cls;
  logic          stop_go;
  logic          dec_pend;
  logic [AW-1:0] vec_next;

  exc_prio_arb u_arb (
    .sys_rst_req (sys_reset_req),
    .mchk_req    (mchk_req),
    .insn_req    (insn_fault_req),
    .ext_req     (ext_irq),
    .dec_pend    (dec_pend),
    .ext_en      (msr_o[MSR_EE]),
    .halted      (check_stop),
    .mchk_en     (msr_o[MSR_ME]),
    .cls         (cls),
    .stop_go     (stop_go)
  );

  exc_vec_gen #(
    .AW         (AW),
    .VEC_BASE   (VEC_BASE),
    .SLOT_SHIFT (SLOT_SHIFT)
  ) u_vec (
    .cls (cls),
    .vec (vec_next)
  );

  exc_state_regs #(
    .AW    (AW),
    .MSR_W (MSR_W)
  ) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .cls            (cls),
    .stop_go        (stop_go),
    .insn_addr      (insn_addr),
    .rfi            (rfi),
    .msr_wr         (msr_wr),
    .msr_wdata      (msr_wdata),
    .dec_event      (dec_event),
    .vec_in         (vec_next),
    .msr_q          (msr_o),
    .srr0_q         (srr0_o),
    .srr1_q         (srr1_o),
    .dec_pend_q     (dec_pend),
    .halted_q       (check_stop),
    .vec_valid_q    (vec_valid),
    .vec_addr_q     (vec_addr),
    .resume_valid_q (resume_valid),
    .resume_addr_q  (resume_addr)
  );

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
  import exc_pkg::*;
#(
  parameter int unsigned   AW         = 32,
  parameter int unsigned   MSR_W      = 8,
  parameter int unsigned   SLOT_SHIFT = 8,
  parameter logic [AW-1:0] VEC_BASE   = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sys_reset_req,
  input logic [AW-1:0]    insn_addr,
  input logic [MSR_W-1:0] msr_o,
  input logic [AW-1:0]    srr0_o,
  input logic [MSR_W-1:0] srr1_o,
  input logic             vec_valid,
  input logic [AW-1:0]    vec_addr,
  input logic             resume_valid,
  input logic [AW-1:0]    resume_addr,
  input logic             check_stop
);

  localparam logic [AW-1:0] RST_VEC = VEC_BASE + (AW'(1) << SLOT_SHIFT);
  localparam logic [AW-1:0] EXT_VEC = VEC_BASE + (AW'(5) << SLOT_SHIFT);
  localparam logic [AW-1:0] DEC_VEC = VEC_BASE + (AW'(9) << SLOT_SHIFT);

  // R4
  save_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_addr != RST_VEC) |->
      (srr0_o == $past(insn_addr) && srr1_o == $past(msr_o)));

  // R5
  entry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (!msr_o[MSR_EE] && !msr_o[MSR_UM]));

  // R6
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && (vec_addr == EXT_VEC || vec_addr == DEC_VEC)) |-> $past(msr_o[MSR_EE]));

  // R8
  check_stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (check_stop && !sys_reset_req) |=> (check_stop && !vec_valid && $stable(msr_o)));

  // R9
  return_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid |-> (msr_o == $past(srr1_o) && resume_addr == $past(srr0_o)));

  // R10
  sys_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> (vec_valid && vec_addr == RST_VEC && msr_o == '0 &&
                       srr0_o == '0 && srr1_o == '0 && !check_stop));

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(
  .AW         (AW),
  .MSR_W      (MSR_W),
  .SLOT_SHIFT (SLOT_SHIFT),
  .VEC_BASE   (VEC_BASE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sys_reset_req (sys_reset_req),
  .insn_addr     (insn_addr),
  .msr_o         (msr_o),
  .srr0_o        (srr0_o),
  .srr1_o        (srr1_o),
  .vec_valid     (vec_valid),
  .vec_addr      (vec_addr),
  .resume_valid  (resume_valid),
  .resume_addr   (resume_addr),
  .check_stop    (check_stop)
);

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;

  localparam int          CLK_PERIOD = 10;
  localparam int          AW         = 32;
  localparam int          MW         = 8;
  localparam logic [31:0] VB         = 32'h0004_0000;

  logic          clk;
  logic          rst_n;
  logic          sys_reset_req, mchk_req, insn_fault_req, ext_irq, dec_event;
  logic [AW-1:0] insn_addr;
  logic          rfi, msr_wr;
  logic [MW-1:0] msr_wdata;
  logic [MW-1:0] msr_o, srr1_o;
  logic [AW-1:0] srr0_o, vec_addr, resume_addr;
  logic          vec_valid, resume_valid, check_stop;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    logic        is_resume;
    logic [31:0] addr;
    string       tag;
  } exp_t;
  exp_t sb[$];

  exc_entry_ctrl #(.AW(AW), .MSR_W(MW), .SLOT_SHIFT(8), .VEC_BASE(VB)) i_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .sys_reset_req(sys_reset_req), .mchk_req(mchk_req),
    .insn_fault_req(insn_fault_req), .ext_irq(ext_irq), .dec_event(dec_event),
    .insn_addr(insn_addr), .rfi(rfi), .msr_wr(msr_wr), .msr_wdata(msr_wdata),
    .msr_o(msr_o), .srr0_o(srr0_o), .srr1_o(srr1_o), .vec_valid(vec_valid),
    .vec_addr(vec_addr), .resume_valid(resume_valid), .resume_addr(resume_addr),
    .check_stop(check_stop)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] vaddr(int slot);
    return VB + 32'(slot) * 32'd256;
  endfunction

  task automatic push_vec(int slot, string tag);
    exp_t e;
    e.is_resume = 1'b0; e.addr = vaddr(slot); e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic push_resume(logic [31:0] a, string tag);
    exp_t e;
    e.is_resume = 1'b1; e.addr = a; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && (vec_valid || resume_valid)) begin
      if (sb.size() == 0) begin
        n_tests++;
        n_fail++;
        $display("FAIL R2 unexpected strobe actual=%b/%h expected=none",
                 resume_valid, resume_valid ? resume_addr : vec_addr);
      end else begin
        e = sb.pop_front();
        check(e.tag, {31'd0, resume_valid, resume_valid ? resume_addr : vec_addr},
                     {31'd0, e.is_resume, e.addr});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 0; sys_reset_req = 0; mchk_req = 0; insn_fault_req = 0; ext_irq = 0;
    dec_event = 0; insn_addr = '0; rfi = 0; msr_wr = 0; msr_wdata = '0;
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    check("R1 msr",        msr_o, 0);
    check("R1 srr0",       srr0_o, 0);
    check("R1 srr1",       srr1_o, 0);
    check("R1 check_stop", check_stop, 0);
    check("R1 strobes",    {vec_valid, resume_valid}, 0);

    // R11 plain write: ext_en | mchk_en | user
    msr_wr = 1; msr_wdata = 8'h07; step; msr_wr = 0;
    check("R11 msr write", msr_o, 8'h07);

    // R2 machine check beats every lower source
    insn_addr = 32'h0000_1000;
    mchk_req = 1; insn_fault_req = 1; ext_irq = 1; dec_event = 1;
    push_vec(2, "R2 R3 mchk wins");
    step;
    mchk_req = 0; insn_fault_req = 0; ext_irq = 0; dec_event = 0;
    check("R4 srr0 on mchk", srr0_o, 32'h0000_1000);
    check("R4 srr1 on mchk", srr1_o, 8'h07);
    check("R5 msr after entry", msr_o, 8'h02);

    // R9 return, then R7 stored decrementer event fires once
    insn_addr = 32'h0000_2000;
    rfi = 1;
    push_resume(32'h0000_1000, "R9 resume addr");
    push_vec(9, "R7 dec after return");
    step; rfi = 0;
    check("R9 msr restored", msr_o, 8'h07);
    step;
    check("R7 srr0 on dec", srr0_o, 32'h0000_2000);
    check("R7 msr after dec", msr_o, 8'h02);
    rfi = 1;
    push_resume(32'h0000_2000, "R9 resume from dec");
    step; rfi = 0;
    step(3);
    check("R7 dec taken once", sb.size(), 0);
    check("R7 msr after second return", msr_o, 8'h07);

    // R2 instruction fault beats external; R6 external waits while masked
    insn_addr = 32'h0000_3000;
    insn_fault_req = 1; ext_irq = 1;
    push_vec(7, "R2 insn over ext");
    step; insn_fault_req = 0;
    step(3);
    check("R6 masked ext waits", {vec_valid, msr_o}, {1'b0, 8'h02});
    rfi = 1;
    push_resume(32'h0000_3000, "R9 resume from insn");
    push_vec(5, "R6 ext after enable");
    step; rfi = 0;
    step; ext_irq = 0;
    check("R6 srr1 on ext", srr1_o, 8'h07);
    rfi = 1;
    push_resume(32'h0000_3000, "R9 resume from ext");
    step; rfi = 0; step;

    // R2 external beats decrementer in the same cycle
    ext_irq = 1; dec_event = 1;
    push_vec(5, "R2 ext over dec");
    step; ext_irq = 0; dec_event = 0;
    rfi = 1;
    push_resume(32'h0000_3000, "R9 resume after ext");
    push_vec(9, "R2 dec after ext");
    step; rfi = 0; step;
    rfi = 1;
    push_resume(32'h0000_3000, "R9 resume after dec");
    step; rfi = 0; step;

    // R11 entry beats a colliding write
    insn_fault_req = 1; msr_wr = 1; msr_wdata = 8'h04;
    push_vec(7, "R11 entry beats write");
    step; insn_fault_req = 0; msr_wr = 0;
    check("R11 write dropped", msr_o, 8'h02);
    msr_wr = 1; msr_wdata = 8'h01; step; msr_wr = 0;
    check("R11 msr ext only", msr_o, 8'h01);

    // R8 disabled machine check halts
    mchk_req = 1; step; mchk_req = 0;
    check("R8 check_stop set", check_stop, 1);
    insn_fault_req = 1; ext_irq = 1; rfi = 1; msr_wr = 1; msr_wdata = 8'h03; dec_event = 1;
    step(2);
    insn_fault_req = 0; ext_irq = 0; rfi = 0; msr_wr = 0; dec_event = 0;
    step;
    check("R8 still halted", check_stop, 1);
    check("R8 msr frozen", msr_o, 8'h01);

    // R10 reset request, together with a machine check
    sys_reset_req = 1; mchk_req = 1;
    push_vec(1, "R10 R2 reset vector");
    step; sys_reset_req = 0; mchk_req = 0;
    check("R10 msr cleared",  msr_o, 0);
    check("R10 srr0 cleared", srr0_o, 0);
    check("R10 srr1 cleared", srr1_o, 0);
    check("R10 halt cleared", check_stop, 0);
    msr_wr = 1; msr_wdata = 8'h01; step; msr_wr = 0;
    step(3);
    check("R10 dec pending cleared", sb.size(), 0);
    summary();
  end

endmodule